// File: doc/BRIEF.md
# Waveform Pattern Generator

This block produces the 8-bit code for a parallel DAC from a single code register. Right after reset it sits in manual mode: the user nudges the code one count at a time with up and down buttons that are already debounced. Each press counts once, no matter how long the button is held.

A run request moves the block into run mode, and it stays there until the next reset. In run mode a programmable timer issues a step every few clock cycles. On each step the selected shape advances: a sawtooth that rolls over, a triangle that bounces between the ends of the code range, a square wave held at each extreme for a set number of steps, or a sine wave read from an internal table. A one-cycle strobe marks every cycle in which the code takes a new value.

Top module: `wavegen_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `code_o` is 0 and `step_stb_o` is 0. The block starts in manual mode.
- R2: In manual mode, at the first clock edge that samples a press (`up_i` or `dn_i` high after being low), the code goes up or down by one, modulo 256. 255 goes up to 0, and 0 goes down to 255.
- R3: A held button acts only once and is ignored until it has been seen low. If new presses of both buttons arrive at the same edge, the code does not change.
- R4: In manual mode, a `run_i` high at a clock edge enters run mode at that edge, and a button at the same edge is ignored. Run mode lasts until reset. While in run mode, `up_i`, `dn_i` and `run_i` have no effect.
- R5: In run mode with step period P (`period_i`, where 0 counts as 1), steps fall on edges P, 2P, 3P and so on, counted after the edge that took the run request.
- R6: With `wave_i` = 0 (sawtooth), each step adds one to the code, and 255 rolls over to 0.
- R7: With `wave_i` = 1 (triangle), the direction starts upward after reset. At 255 the next step gives 254, and at 0 the next step gives 1. Neither end value is repeated.
- R8: With `wave_i` = 2 (square), the code holds its value and then switches after every H steps (`half_i`, where 0 counts as 1). The first switch goes to 255, and the switches then alternate between 0 and 255.
- R9: With `wave_i` = 3 (sine), each step loads table entry n, where n starts at 0 after reset and wraps after 255. Entry n = floor(127.5 + 127.5*sin(2*pi*n/256) + 0.5).
- R10: `step_stb_o` is high for exactly the cycles in which `code_o` differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_i | input | 2 | Shape select: 0 saw, 1 triangle, 2 square, 3 sine |
| period_i | input | 16 | Clock cycles per run-mode step (0 counts as 1) |
| half_i | input | 16 | Steps per square half cycle (0 counts as 1) |
| up_i | input | 1 | Debounced up button, level |
| dn_i | input | 1 | Debounced down button, level |
| run_i | input | 1 | Request to enter run mode |
| code_o | output | 8 | DAC code, registered |
| step_stb_o | output | 1 | One-cycle pulse when the code changes |

## Verification
The assertions that check step spacing and shape transitions assume that `wave_i`, `period_i` and `half_i` stay steady while run mode is active. The bench sets them before a run starts and leaves them alone until the next reset. Buttons are taken to be clean levels with no bounce, so the bench drives each press as a level held for one or more whole cycles. Every input changes on the falling edge, away from the sampling edge.

// File: rtl/wg_pkg.sv
`timescale 1ns/1ps
package wg_pkg;
  typedef enum logic [1:0] {
    WAVE_SAW = 2'd0,
    WAVE_TRI = 2'd1,
    WAVE_SQR = 2'd2,
    WAVE_SIN = 2'd3
  } wave_e;
endpackage

// File: rtl/wg_press_detect.sv
`timescale 1ns/1ps
// Acts once per press: a hit needs the button low at an earlier edge.
module wg_press_detect (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic hit_o
);
  logic armed_q;

  assign hit_o = btn_i & armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b1;
    else     armed_q <= ~btn_i;
  end

  p_single_hit_r3: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/wg_step_timer.sv
`timescale 1ns/1ps
// Issues one step every PERIOD enabled cycles (0 treated as 1).
module wg_step_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             step_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] eff;
  logic             last;

  assign eff    = (period_i == '0) ? PER_W'(1) : period_i;
  assign last   = (cnt_q >= eff - PER_W'(1));
  assign step_o = en_i & last;

  always_ff @(posedge clk) begin
    if (rst || !en_i) cnt_q <= '0;
    else if (last)    cnt_q <= '0;
    else              cnt_q <= cnt_q + PER_W'(1);
  end

  p_step_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (step_o && period_i > PER_W'(1)) |=> (!step_o || period_i <= PER_W'(1)));
endmodule

// File: rtl/wg_sine_rom.sv
`timescale 1ns/1ps
// Sine table with a registered read port, laid out for block RAM.
module wg_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;
  localparam real TWO_PI = 6.283185307179586;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real amp;
      real v;
      amp = ((2.0 ** DW) - 1.0) / 2.0;
      v = amp + amp * $sin(TWO_PI * i / DEPTH);
      mem[i] = DW'($rtoi(v + 0.5));
    end
  end

  always_ff @(posedge clk) data_o <= mem[addr_i];
endmodule

// File: rtl/wg_core.sv
`timescale 1ns/1ps
// Mode control, shape sequencing and the shared code register.
module wg_core
  import wg_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wave_e             wave_i,
  input  logic [PER_W-1:0]  half_i,
  input  logic              run_i,
  input  logic              up_hit_i,
  input  logic              dn_hit_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] rom_q_i,
  output logic              running_o,
  output logic [CODE_W-1:0] rom_addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic              strobe_o
);
  localparam logic [CODE_W-1:0] TOP = '1;
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic              running_q, running_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              strobe_q;
  logic              dir_up_q, dir_up_d;
  logic              sq_hi_q, sq_hi_d;
  logic [PER_W-1:0]  hcnt_q, hcnt_d;
  logic [CODE_W-1:0] idx_q, idx_d;
  logic [PER_W-1:0]  half_eff;

  assign half_eff = (half_i == '0) ? PER_W'(1) : half_i;

  always_comb begin
    running_d = running_q;
    code_d    = code_q;
    dir_up_d  = dir_up_q;
    sq_hi_d   = sq_hi_q;
    hcnt_d    = hcnt_q;
    idx_d     = idx_q;
    if (!running_q) begin
      if (run_i)                       running_d = 1'b1;
      else if (up_hit_i && !dn_hit_i)  code_d = code_q + ONE;
      else if (dn_hit_i && !up_hit_i)  code_d = code_q - ONE;
    end else if (step_i) begin
      case (wave_i)
        WAVE_SAW: code_d = code_q + ONE;
        WAVE_TRI: begin
          if (dir_up_q) begin
            if (code_q == TOP) begin
              code_d   = code_q - ONE;
              dir_up_d = 1'b0;
            end else code_d = code_q + ONE;
          end else begin
            if (code_q == '0) begin
              code_d   = ONE;
              dir_up_d = 1'b1;
            end else code_d = code_q - ONE;
          end
        end
        WAVE_SQR: begin
          if (hcnt_q >= half_eff - PER_W'(1)) begin
            hcnt_d  = '0;
            sq_hi_d = ~sq_hi_q;
            code_d  = sq_hi_q ? '0 : TOP;
          end else hcnt_d = hcnt_q + PER_W'(1);
        end
        WAVE_SIN: begin
          code_d = rom_q_i;
          idx_d  = idx_q + ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      code_q    <= '0;
      strobe_q  <= 1'b0;
      dir_up_q  <= 1'b1;
      sq_hi_q   <= 1'b0;
      hcnt_q    <= '0;
      idx_q     <= '0;
    end else begin
      running_q <= running_d;
      code_q    <= code_d;
      strobe_q  <= (code_d != code_q);
      dir_up_q  <= dir_up_d;
      sq_hi_q   <= sq_hi_d;
      hcnt_q    <= hcnt_d;
      idx_q     <= idx_d;
    end
  end

  assign running_o  = running_q;
  assign rom_addr_o = idx_d;
  assign code_o     = code_q;
  assign strobe_o   = strobe_q;

  p_run_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    running_q |=> running_q);
  p_manual_unit_r2: assert property (@(posedge clk) disable iff (rst)
    (!running_q && code_q != $past(code_q)) |->
      (code_q == $past(code_q) + ONE || code_q == $past(code_q) - ONE));
  p_saw_step_r6: assert property (@(posedge clk) disable iff (rst)
    (running_q && step_i && wave_i == WAVE_SAW) |=> code_q == $past(code_q) + ONE);
  p_tri_peak_r7: assert property (@(posedge clk) disable iff (rst)
    (running_q && step_i && wave_i == WAVE_TRI && code_q == TOP) |=> code_q == TOP - ONE);
  p_tri_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (running_q && step_i && wave_i == WAVE_TRI && code_q == '0) |=> code_q == ONE);
  p_sine_load_r9: assert property (@(posedge clk) disable iff (rst)
    (running_q && step_i && wave_i == WAVE_SIN) |=> code_q == $past(rom_q_i));
  p_strobe_change_r10: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> code_q != $past(code_q));
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !strobe_q |-> $stable(code_q));
endmodule

// File: rtl/wavegen_top.sv
`timescale 1ns/1ps
module wavegen_top #(
  parameter int CODE_W = 8,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        wave_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [PER_W-1:0]  half_i,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o,
  output logic              step_stb_o
);
  import wg_pkg::*;

  localparam int NBTN = 2;

  logic [NBTN-1:0]   btn;
  logic [NBTN-1:0]   hit;
  logic              running;
  logic              step;
  logic [CODE_W-1:0] rom_addr;
  logic [CODE_W-1:0] rom_q;

  assign btn = {dn_i, up_i};

  for (genvar g = 0; g < NBTN; g++) begin : g_btn
    wg_press_detect u_press (
      .clk  (clk),
      .rst  (rst),
      .btn_i(btn[g]),
      .hit_o(hit[g])
    );
  end

  wg_step_timer #(.PER_W(PER_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en_i    (running),
    .period_i(period_i),
    .step_o  (step)
  );

  wg_sine_rom #(.AW(CODE_W), .DW(CODE_W)) u_rom (
    .clk   (clk),
    .addr_i(rom_addr),
    .data_o(rom_q)
  );

  wg_core #(.CODE_W(CODE_W), .PER_W(PER_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .wave_i    (wave_e'(wave_i)),
    .half_i    (half_i),
    .run_i     (run_i),
    .up_hit_i  (hit[0]),
    .dn_hit_i  (hit[1]),
    .step_i    (step),
    .rom_q_i   (rom_q),
    .running_o (running),
    .rom_addr_o(rom_addr),
    .code_o    (code_o),
    .strobe_o  (step_stb_o)
  );
endmodule

// File: tb/wavegen_top_tb_top.sv
`timescale 1ns/1ps
module wavegen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wave = 2'd0;
  logic [15:0] per = 16'd1;
  logic [15:0] half = 16'd1;
  logic        up = 1'b0, dn = 1'b0, run = 1'b0;
  logic [7:0]  code;
  logic        stb;
  int          checks = 0;
  int          fails = 0;
  int          sine_ref [256];

  always #2 clk = ~clk;

  wavegen_top dut_i (
    .clk(clk), .rst(rst), .wave_i(wave), .period_i(per), .half_i(half),
    .up_i(up), .dn_i(dn), .run_i(run), .code_o(code), .step_stb_o(stb)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up = 1'b0; dn = 1'b0; run = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk) run = 1'b1;
    @(negedge clk) run = 1'b0;
  endtask

  task automatic wait_step(int p);
    repeat (p) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_btn(logic u, logic d);
    up = u; dn = d;
    @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 code after reset", code, 0);
    check("R1 strobe after reset", stb, 0);
  endtask

  task automatic test_manual();
    do_reset();
    set_btn(1, 0);
    check("R2 up press", code, 1);
    check("R10 strobe on press", stb, 1);
    repeat (4) set_btn(1, 0);
    check("R3 held up acts once", code, 1);
    check("R10 no strobe while held", stb, 0);
    set_btn(0, 0); set_btn(1, 0);
    check("R2 second up", code, 2);
    set_btn(0, 0); set_btn(0, 1);
    check("R2 down press", code, 1);
    set_btn(0, 0); set_btn(0, 1);
    set_btn(0, 0); set_btn(0, 1);
    check("R2 down wraps 0 to 255", code, 255);
    set_btn(0, 0); set_btn(1, 1);
    check("R3 simultaneous presses cancel", code, 255);
    check("R3 no strobe on cancel", stb, 0);
    set_btn(0, 0); set_btn(1, 0);
    check("R2 up wraps 255 to 0", code, 0);
    set_btn(0, 0);
  endtask

  task automatic test_saw();
    do_reset();
    wave = 2'd0; per = 16'd3;
    start_run();
    for (int k = 1; k <= 260; k++) begin
      wait_step(3);
      check("R6 sawtooth value", code, k % 256);
      if (k <= 3 || k == 256) check("R10 strobe on saw step", stb, 1);
    end
  endtask

  task automatic test_tri();
    do_reset();
    wave = 2'd1; per = 16'd1;
    start_run();
    for (int k = 1; k <= 520; k++) begin
      int m;
      m = k % 510;
      wait_step(1);
      check("R7 triangle value", code, (m <= 255) ? m : 510 - m);
    end
  endtask

  task automatic test_square();
    do_reset();
    wave = 2'd2; per = 16'd2; half = 16'd3;
    start_run();
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R10 no strobe between steps", stb, 0);
      @(negedge clk);
      check("R8 square level", code, ((k / 3) % 2 == 1) ? 255 : 0);
      check("R10 strobe only on switch", stb, (k % 3 == 0) ? 1 : 0);
    end
  endtask

  task automatic test_sine();
    do_reset();
    wave = 2'd3; per = 16'd1;
    start_run();
    for (int k = 1; k <= 300; k++) begin
      wait_step(1);
      check("R9 sine sample", code, sine_ref[(k - 1) % 256]);
    end
  endtask

  task automatic test_run_locks();
    do_reset();
    wave = 2'd0; per = 16'd4;
    start_run();
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk) up = 1'b1;
      @(negedge clk) begin up = 1'b0; dn = 1'b1; run = 1'b1; end
      @(negedge clk) begin dn = 1'b0; run = 1'b0; end
      check("R4 buttons ignored in run", code, k - 1);
      @(negedge clk);
      check("R4 run continues", code, k);
    end
  endtask

  task automatic test_period();
    do_reset();
    wave = 2'd0; per = 16'd0;
    start_run();
    for (int k = 1; k <= 5; k++) begin
      wait_step(1);
      check("R5 period zero steps each cycle", code, k);
    end
    do_reset();
    per = 16'd5;
    start_run();
    repeat (4) @(negedge clk);
    check("R5 no step before period", code, 0);
    @(negedge clk);
    check("R5 step at period", code, 1);
    do_reset();
    check("R1 reset clears run code", code, 0);
    set_btn(1, 0);
    check("R4 reset returns to manual", code, 1);
    set_btn(0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      real v;
      v = 127.5 + 127.5 * $sin(6.283185307179586 * i / 256.0);
      sine_ref[i] = $rtoi(v + 0.5);
    end
    test_reset();
    test_manual();
    test_saw();
    test_tri();
    test_square();
    test_sine();
    test_run_locks();
    test_period();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule